// File: doc/BRIEF.md
# Interrupt Bid Arbitration Controller

This block decides which of eighteen interrupt sources in a four-channel serial controller gets served next. Each source is a receive FIFO, a transmit FIFO, a break detector, a change-of-state detector (one of each per channel) or one of two counter/timers. A source that is enabled and active forms an 8-bit bid. Fill-based sources put a live byte count in the top bits of their bid. Event sources put a programmable 3-bit priority there. The lower bits hold a fixed type code and the channel number, so every bid is unique and the largest one wins.

The winner is latched once per enabled cycle. The latched winner is compared against a programmable threshold to drive an active-low, level-sensitive interrupt request. On an interrupt acknowledge, or on an update command, the latched winner is copied into a current-interrupt register. An acknowledge also returns a vector built from a base register and the winner's fields, and raises a data acknowledge. FIFO counts, error and event flags, masks and priorities all arrive as inputs.

Top module: `intr_bid_arb`

## Requirements
- R1: A receive bid is {count[2:0], err, 2'b11, ch[1:0]}, where count is the receive fill saturated so that eight bytes encode as 7 and err is the channel's receive error flag.
- R2: A receive source bids only when its fill meets its 2-bit level select: 00 needs 1 or more, 01 needs 3 or more, 10 needs 6 or more, 11 needs 8 bytes. A receive FIFO holding zero bytes never bids.
- R3: A transmit bid is {1'b0, free[2:0], 2'b10, ch[1:0]}, with eight free slots encoded as 7. It bids only when its free count meets its select: 00 needs exactly 8, 01 needs 4 or more, 10 needs 6 or more, 11 needs 1 or more. A full transmit FIFO never bids.
- R4: Break, change-of-state and counter/timer bids are {prio[2:0], type[2:0], ch[1:0]} with type 100, 001 and 101 respectively. Counter/timer 0 reports channel 01 and counter/timer 1 reports channel 11. These sources bid only while their flag is high.
- R5: Mask bit order is [3:0] receive ch0..3, [7:4] transmit, [11:8] break, [15:12] change-of-state, [17:16] counter/timers. A source whose mask bit is 0 does not bid. With no bidder, the current-interrupt register loads FFh and the request stays negated.
- R6: The numerically highest bid among the bidders wins, and no two simultaneous bids are ever equal.
- R7: irq_n goes low two clocks after the inputs when the latched winner is strictly greater than the threshold. It is high when there is no winner or the winner is less than or equal to the threshold.
- R8: On a cycle with iack or upd high, the current-interrupt register loads the latched winner (FFh with none), and the winner latch holds for that cycle. At all other times the current-interrupt register is unchanged.
- R9: On iack, vec_out loads from the vector mode. Mode 00 gives the base. Mode 01 gives base[7:2] with the winner's bits [1:0]. Mode 10 gives base[7:5] with the winner's bits [4:0]. Mode 11 leaves vec_out unchanged and keeps vec_drive low. vec_drive pulses for one clock otherwise.
- R10: dack pulses high for exactly the clock after each iack, in every vector mode. It does not pulse for upd.
- R11: While eval_en is low, the winner latch holds its value.
- R12: After reset, irq_n is 1, the current-interrupt register is FFh, vec_out is 00h, and dack and vec_drive are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| eval_en | input | 1 | Allows the winner latch to update |
| src_mask | input | 18 | Per-source enable, order as in R5 |
| rx_fill | input | 16 | Receive fill per channel, 4 bits each, 0..8 |
| rx_err | input | 4 | Receive error flag per channel |
| rx_lvl | input | 8 | Receive level select per channel, 2 bits each |
| tx_free | input | 16 | Transmit free slots per channel, 4 bits each, 0..8 |
| tx_lvl | input | 8 | Transmit level select per channel, 2 bits each |
| brk_flag | input | 4 | Break event flag per channel |
| brk_prio | input | 12 | Break priority per channel, 3 bits each |
| cos_flag | input | 4 | Change-of-state flag per channel |
| cos_prio | input | 12 | Change-of-state priority per channel, 3 bits each |
| ct_flag | input | 2 | Counter/timer ready flag |
| ct_prio | input | 6 | Counter/timer priority, 3 bits each |
| thresh | input | 8 | Request threshold |
| vec_base | input | 8 | Vector base value |
| vec_mode | input | 2 | Vector build mode |
| iack | input | 1 | Interrupt acknowledge, one clock |
| upd | input | 1 | Update current-interrupt command, one clock |
| irq_n | output | 1 | Active-low interrupt request |
| cir | output | 8 | Current-interrupt register |
| vec_out | output | 8 | Vector value |
| vec_drive | output | 1 | Vector is valid this clock |
| dack | output | 1 | Data acknowledge, one clock |

## Verification
The hardest case is an acknowledge that arrives while the inputs are changing. The stored value must then be the winner from the previous clock, not the one the current inputs would produce, and the latch must skip that evaluation. A random phase changes every source, mask, select and priority on every clock, and fires iack and upd sparsely. A behavioural model checks the stored value, the vector and the request on each clock. The same model counts equal-valued bids whenever two or more sources bid, to confirm that the type and channel fields keep every bid distinct. Directed cases first pin down each bid format at its saturation and level-select edges.

// File: rtl/intr_bid_pkg.sv
package intr_bid_pkg;
  localparam int BIDW = 8;
  localparam int PRW  = 3;
  localparam int CHW  = 2;
  typedef logic [BIDW-1:0] bid_t;

  localparam logic [1:0] TY_RX  = 2'b11;
  localparam logic [1:0] TY_TX  = 2'b10;
  localparam logic [2:0] TY_BRK = 3'b100;
  localparam logic [2:0] TY_COS = 3'b001;
  localparam logic [2:0] TY_CT  = 3'b101;

  // Saturate a 0..15 count into three bits (eight and above read as 7).
  function automatic logic [2:0] sat3(input logic [3:0] n);
    return (n > 4'd7) ? 3'd7 : n[2:0];
  endfunction
endpackage

// File: rtl/intr_bid_former.sv
module intr_bid_former
  import intr_bid_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int NCT   = 2,
  parameter int FILLW = 4,
  localparam int NSRC = 4*NCH + NCT
) (
  input  logic [NSRC-1:0]      src_mask,
  input  logic [NCH*FILLW-1:0] rx_fill,
  input  logic [NCH-1:0]       rx_err,
  input  logic [NCH*2-1:0]     rx_lvl,
  input  logic [NCH*FILLW-1:0] tx_free,
  input  logic [NCH*2-1:0]     tx_lvl,
  input  logic [NCH-1:0]       brk_flag,
  input  logic [NCH*PRW-1:0]   brk_prio,
  input  logic [NCH-1:0]       cos_flag,
  input  logic [NCH*PRW-1:0]   cos_prio,
  input  logic [NCT-1:0]       ct_flag,
  input  logic [NCT*PRW-1:0]   ct_prio,
  output logic [NSRC*BIDW-1:0] bids,
  output logic [NSRC-1:0]      req
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam logic [CHW-1:0] CH = CHW'(c);
    logic [FILLW-1:0] rf, tf;
    logic             rx_ok, tx_ok;
    assign rf = rx_fill[c*FILLW +: FILLW];
    assign tf = tx_free[c*FILLW +: FILLW];

    always_comb begin
      unique case (rx_lvl[c*2 +: 2])
        2'b00:   rx_ok = rf >= FILLW'(1);
        2'b01:   rx_ok = rf >= FILLW'(3);
        2'b10:   rx_ok = rf >= FILLW'(6);
        default: rx_ok = rf >= FILLW'(8);
      endcase
      unique case (tx_lvl[c*2 +: 2])
        2'b00:   tx_ok = tf >= FILLW'(8);
        2'b01:   tx_ok = tf >= FILLW'(4);
        2'b10:   tx_ok = tf >= FILLW'(6);
        default: tx_ok = tf >= FILLW'(1);
      endcase
    end

    assign bids[c*BIDW +: BIDW]         = {sat3(4'(rf)), rx_err[c], TY_RX, CH};
    assign req[c]                        = src_mask[c] & rx_ok;
    assign bids[(NCH+c)*BIDW +: BIDW]   = {1'b0, sat3(4'(tf)), TY_TX, CH};
    assign req[NCH+c]                    = src_mask[NCH+c] & tx_ok;
    assign bids[(2*NCH+c)*BIDW +: BIDW] = {brk_prio[c*PRW +: PRW], TY_BRK, CH};
    assign req[2*NCH+c]                  = src_mask[2*NCH+c] & brk_flag[c];
    assign bids[(3*NCH+c)*BIDW +: BIDW] = {cos_prio[c*PRW +: PRW], TY_COS, CH};
    assign req[3*NCH+c]                  = src_mask[3*NCH+c] & cos_flag[c];
  end

  for (genvar k = 0; k < NCT; k++) begin : g_ct
    localparam logic [CHW-1:0] CTCH = CHW'(2*k + 1);
    assign bids[(4*NCH+k)*BIDW +: BIDW] = {ct_prio[k*PRW +: PRW], TY_CT, CTCH};
    assign req[4*NCH+k]                  = src_mask[4*NCH+k] & ct_flag[k];
  end
endmodule

// File: rtl/intr_bid_pick.sv
module intr_bid_pick
  import intr_bid_pkg::*;
#(
  parameter int NSRC = 18
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 eval,
  input  logic [NSRC*BIDW-1:0] bids,
  input  logic [NSRC-1:0]      req,
  output bid_t                 win,
  output logic                 win_v
);
  bid_t best;
  logic best_v;

  always_comb begin
    best   = '0;
    best_v = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (req[i] && (!best_v || bids[i*BIDW +: BIDW] > best)) begin
        best   = bids[i*BIDW +: BIDW];
        best_v = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win   <= '0;
      win_v <= 1'b0;
    end else if (eval) begin
      win   <= best;
      win_v <= best_v;
    end
  end
endmodule

// File: rtl/intr_bid_vec.sv
module intr_bid_vec
  import intr_bid_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       iack,
  input  logic       upd,
  input  bid_t       win,
  input  logic       win_v,
  input  logic [7:0] vec_base,
  input  logic [1:0] vec_mode,
  output logic [7:0] cir,
  output logic [7:0] vec_out,
  output logic       vec_drive,
  output logic       dack
);
  bid_t cur;
  assign cur = win_v ? win : 8'hFF;

  always_ff @(posedge clk) begin
    if (rst) begin
      cir       <= 8'hFF;
      vec_out   <= 8'h00;
      vec_drive <= 1'b0;
      dack      <= 1'b0;
    end else begin
      dack      <= iack;
      vec_drive <= iack && (vec_mode != 2'b11);
      if (iack || upd) cir <= cur;
      if (iack) begin
        unique case (vec_mode)
          2'b00:   vec_out <= vec_base;
          2'b01:   vec_out <= {vec_base[7:2], cur[1:0]};
          2'b10:   vec_out <= {vec_base[7:5], cur[4:0]};
          default: vec_out <= vec_out;
        endcase
      end
    end
  end
endmodule

// File: rtl/intr_bid_arb.sv
module intr_bid_arb
  import intr_bid_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int NCT   = 2,
  parameter int FILLW = 4,
  localparam int NSRC = 4*NCH + NCT
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 eval_en,
  input  logic [NSRC-1:0]      src_mask,
  input  logic [NCH*FILLW-1:0] rx_fill,
  input  logic [NCH-1:0]       rx_err,
  input  logic [NCH*2-1:0]     rx_lvl,
  input  logic [NCH*FILLW-1:0] tx_free,
  input  logic [NCH*2-1:0]     tx_lvl,
  input  logic [NCH-1:0]       brk_flag,
  input  logic [NCH*PRW-1:0]   brk_prio,
  input  logic [NCH-1:0]       cos_flag,
  input  logic [NCH*PRW-1:0]   cos_prio,
  input  logic [NCT-1:0]       ct_flag,
  input  logic [NCT*PRW-1:0]   ct_prio,
  input  logic [7:0]           thresh,
  input  logic [7:0]           vec_base,
  input  logic [1:0]           vec_mode,
  input  logic                 iack,
  input  logic                 upd,
  output logic                 irq_n,
  output logic [7:0]           cir,
  output logic [7:0]           vec_out,
  output logic                 vec_drive,
  output logic                 dack
);
  logic [NSRC*BIDW-1:0] bids;
  logic [NSRC-1:0]      req;
  bid_t                 win;
  logic                 win_v;
  logic                 eval;

  assign eval = eval_en & ~iack & ~upd;

  intr_bid_former #(.NCH(NCH), .NCT(NCT), .FILLW(FILLW)) u_form (
    .src_mask(src_mask), .rx_fill(rx_fill), .rx_err(rx_err), .rx_lvl(rx_lvl),
    .tx_free(tx_free), .tx_lvl(tx_lvl), .brk_flag(brk_flag), .brk_prio(brk_prio),
    .cos_flag(cos_flag), .cos_prio(cos_prio), .ct_flag(ct_flag), .ct_prio(ct_prio),
    .bids(bids), .req(req)
  );

  intr_bid_pick #(.NSRC(NSRC)) u_pick (
    .clk(clk), .rst(rst), .eval(eval), .bids(bids), .req(req),
    .win(win), .win_v(win_v)
  );

  intr_bid_vec u_vec (
    .clk(clk), .rst(rst), .iack(iack), .upd(upd), .win(win), .win_v(win_v),
    .vec_base(vec_base), .vec_mode(vec_mode), .cir(cir), .vec_out(vec_out),
    .vec_drive(vec_drive), .dack(dack)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_n <= 1'b1;
    else     irq_n <= ~(win_v && (win > thresh));
  end
endmodule

// File: rtl/intr_bid_arb_chk.sv
module intr_bid_arb_chk (
  input logic       clk,
  input logic       rst,
  input logic       eval_en,
  input logic       iack,
  input logic       upd,
  input logic [7:0] thresh,
  input logic [7:0] vec_base,
  input logic [1:0] vec_mode,
  input logic [7:0] win,
  input logic       win_v,
  input logic       irq_n,
  input logic [7:0] cir,
  input logic [7:0] vec_out,
  input logic       vec_drive,
  input logic       dack
);
  assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    !win_v |=> irq_n);
  assert_irq_above_R7: assert property (@(posedge clk) disable iff (rst)
    (win_v && win > thresh) |=> !irq_n);
  assert_irq_below_R7: assert property (@(posedge clk) disable iff (rst)
    (win_v && win <= thresh) |=> irq_n);
  assert_cir_load_R8: assert property (@(posedge clk) disable iff (rst)
    (iack || upd) |=> cir == ($past(win_v) ? $past(win) : 8'hFF));
  assert_cir_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !(iack || upd) |=> $stable(cir));
  assert_latch_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (!eval_en || iack || upd) |=> ($stable(win) && $stable(win_v)));
  assert_dack_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    iack |=> dack);
  assert_dack_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    !iack |=> !dack);
  assert_mode3_nodrive_R9: assert property (@(posedge clk) disable iff (rst)
    (iack && vec_mode == 2'b11) |=> (!vec_drive && $stable(vec_out)));
  assert_mode0_base_R9: assert property (@(posedge clk) disable iff (rst)
    (iack && vec_mode == 2'b00) |=> (vec_drive && vec_out == $past(vec_base)));
endmodule

bind intr_bid_arb intr_bid_arb_chk u_chk (
  .clk(clk), .rst(rst), .eval_en(eval_en), .iack(iack), .upd(upd),
  .thresh(thresh), .vec_base(vec_base), .vec_mode(vec_mode),
  .win(win), .win_v(win_v), .irq_n(irq_n), .cir(cir), .vec_out(vec_out),
  .vec_drive(vec_drive), .dack(dack)
);

// File: tb/intr_bid_arb_tb_top.sv
module intr_bid_arb_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        eval_en = 1'b1;
  logic [17:0] src_mask = '0;
  logic [15:0] rx_fill = '0;
  logic [3:0]  rx_err = '0;
  logic [7:0]  rx_lvl = '0;
  logic [15:0] tx_free = '0;
  logic [7:0]  tx_lvl = '0;
  logic [3:0]  brk_flag = '0;
  logic [11:0] brk_prio = '0;
  logic [3:0]  cos_flag = '0;
  logic [11:0] cos_prio = '0;
  logic [1:0]  ct_flag = '0;
  logic [5:0]  ct_prio = '0;
  logic [7:0]  thresh = '0;
  logic [7:0]  vec_base = '0;
  logic [1:0]  vec_mode = '0;
  logic        iack = 1'b0;
  logic        upd = 1'b0;
  logic        irq_n, vec_drive, dack;
  logic [7:0]  cir, vec_out;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  intr_bid_arb dut_i (
    .clk(clk), .rst(rst), .eval_en(eval_en), .src_mask(src_mask),
    .rx_fill(rx_fill), .rx_err(rx_err), .rx_lvl(rx_lvl), .tx_free(tx_free),
    .tx_lvl(tx_lvl), .brk_flag(brk_flag), .brk_prio(brk_prio),
    .cos_flag(cos_flag), .cos_prio(cos_prio), .ct_flag(ct_flag),
    .ct_prio(ct_prio), .thresh(thresh), .vec_base(vec_base),
    .vec_mode(vec_mode), .iack(iack), .upd(upd), .irq_n(irq_n), .cir(cir),
    .vec_out(vec_out), .vec_drive(vec_drive), .dack(dack)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference ----------------
  task automatic ref_best(output bit v, output logic [7:0] b, output int ties);
    int vals[$];
    int best = -1;
    for (int c = 0; c < 4; c++) begin
      int f = rx_fill[c*4 +: 4];
      int e = tx_free[c*4 +: 4];
      int lim;
      bit ok;
      lim = (rx_lvl[c*2 +: 2] == 0) ? 1 : (rx_lvl[c*2 +: 2] == 1) ? 3 :
            (rx_lvl[c*2 +: 2] == 2) ? 6 : 8;
      if (src_mask[c] && f >= lim)
        vals.push_back((f > 7 ? 7 : f) * 32 + rx_err[c] * 16 + 12 + c);
      case (tx_lvl[c*2 +: 2])
        2'd0: ok = (e == 8);
        2'd1: ok = (e >= 4);
        2'd2: ok = (e >= 6);
        default: ok = (e >= 1);
      endcase
      if (src_mask[4+c] && ok) vals.push_back((e > 7 ? 7 : e) * 16 + 8 + c);
      if (src_mask[8+c] && brk_flag[c]) vals.push_back(brk_prio[c*3 +: 3] * 32 + 16 + c);
      if (src_mask[12+c] && cos_flag[c]) vals.push_back(cos_prio[c*3 +: 3] * 32 + 4 + c);
    end
    for (int k = 0; k < 2; k++)
      if (src_mask[16+k] && ct_flag[k]) vals.push_back(ct_prio[k*3 +: 3] * 32 + 20 + 2*k + 1);
    ties = 0;
    foreach (vals[i]) if (vals[i] > best) best = vals[i];
    foreach (vals[i]) if (vals[i] == best) ties++;
    v = (vals.size() > 0);
    b = v ? 8'(best) : 8'h00;
    if (vals.size() > 1) chk(ties == 1, "R6 bids unique", ties, 1);
  endtask

  bit         m_wv;
  logic [7:0] m_win, m_cir, m_vec;
  logic       m_irqn, m_dack, m_vd;

  always @(posedge clk) begin
    if (rst) begin
      m_wv <= 0; m_win <= 0; m_irqn <= 1; m_cir <= 8'hFF;
      m_vec <= 0; m_dack <= 0; m_vd <= 0;
    end else begin
      bit bv; logic [7:0] bb; int t; logic [7:0] cur;
      ref_best(bv, bb, t);
      cur = m_wv ? m_win : 8'hFF;
      if (eval_en && !iack && !upd) begin m_wv <= bv; m_win <= bb; end
      m_irqn <= !(m_wv && m_win > thresh);
      if (iack || upd) m_cir <= cur;
      m_dack <= iack;
      m_vd   <= iack && vec_mode != 2'b11;
      if (iack)
        case (vec_mode)
          2'b00: m_vec <= vec_base;
          2'b01: m_vec <= {vec_base[7:2], cur[1:0]};
          2'b10: m_vec <= {vec_base[7:5], cur[4:0]};
          default: ;
        endcase
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(irq_n === m_irqn, "R7 irq_n", irq_n, m_irqn);
      chk(cir === m_cir, "R8 cir", cir, m_cir);
      chk(vec_out === m_vec, "R9 vec_out", vec_out, m_vec);
      chk(vec_drive === m_vd, "R9 vec_drive", vec_drive, m_vd);
      chk(dack === m_dack, "R10 dack", dack, m_dack);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic idle();
    src_mask = '0; rx_fill = '0; rx_err = '0; rx_lvl = '0; tx_free = '0;
    tx_lvl = '0; brk_flag = '0; brk_prio = '0; cos_flag = '0; cos_prio = '0;
    ct_flag = '0; ct_prio = '0; thresh = '0; eval_en = 1; iack = 0; upd = 0;
  endtask

  task automatic probe(input logic [7:0] exp, input string tag);
    tick();
    upd = 1;
    tick();
    upd = 0;
    @(negedge clk);
    chk(cir === exp, tag, cir, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    chk(irq_n === 1'b1, "R12 reset irq_n", irq_n, 1);
    chk(cir === 8'hFF, "R12 reset cir", cir, 8'hFF);
    chk(vec_out === 8'h00, "R12 reset vec_out", vec_out, 0);
    chk(dack === 1'b0 && vec_drive === 1'b0, "R12 reset dack/drive", {dack, vec_drive}, 0);

    // R5: all sources active but masked
    rx_fill = 16'h8888; tx_free = 16'h8888; brk_flag = '1; cos_flag = '1; ct_flag = '1;
    probe(8'hFF, "R5 masked -> none");
    chk(irq_n === 1'b1, "R5 no request", irq_n, 1);

    // R1: saturation and error bit
    idle(); src_mask[2] = 1; rx_fill[8 +: 4] = 8; rx_err[2] = 1;
    probe(8'hFE, "R1 rx ch2 full+err");
    idle(); src_mask[0] = 1; rx_fill[0 +: 4] = 5;
    probe(8'hAC, "R1 rx ch0 fill5");

    // R2: level select gating
    idle(); src_mask[1] = 1; rx_lvl[2 +: 2] = 2'b01; rx_fill[4 +: 4] = 2;
    probe(8'hFF, "R2 fill2 below 3");
    rx_fill[4 +: 4] = 3;
    probe(8'h6D, "R2 fill3 meets 3");
    rx_lvl[2 +: 2] = 2'b11; rx_fill[4 +: 4] = 7;
    probe(8'hFF, "R2 fill7 below 8");
    rx_fill[4 +: 4] = 8;
    probe(8'hED, "R2 fill8 meets 8");
    rx_lvl[2 +: 2] = 2'b00; rx_fill[4 +: 4] = 0;
    probe(8'hFF, "R2 empty rx no bid");

    // R3: transmit format and gating
    idle(); src_mask[7] = 1; tx_free[12 +: 4] = 8;
    probe(8'h7B, "R3 tx ch3 all free");
    tx_free[12 +: 4] = 7;
    probe(8'hFF, "R3 tx 7 free sel00");
    tx_lvl[6 +: 2] = 2'b11; tx_free[12 +: 4] = 0;
    probe(8'hFF, "R3 full tx no bid");
    tx_lvl[6 +: 2] = 2'b01; tx_free[12 +: 4] = 4;
    probe(8'h4B, "R3 tx 4 free sel01");

    // R4: event bids
    idle(); src_mask[9] = 1; brk_flag[1] = 1; brk_prio[3 +: 3] = 5;
    probe(8'hB1, "R4 break ch1");
    idle(); src_mask[14] = 1; cos_flag[2] = 1; cos_prio[6 +: 3] = 3;
    probe(8'h66, "R4 cos ch2");
    idle(); src_mask[17] = 1; ct_flag[1] = 1; ct_prio[3 +: 3] = 6;
    probe(8'hD7, "R4 ct1 channel 11");
    idle(); src_mask[16] = 1; ct_flag[0] = 1; ct_prio[0 +: 3] = 2;
    probe(8'h55, "R4 ct0 channel 01");

    // R6: highest wins
    idle(); src_mask = 18'h0_0291; rx_fill[0 +: 4] = 5; tx_free[12 +: 4] = 8;
    brk_flag[1] = 1; brk_prio[3 +: 3] = 5;
    src_mask[14] = 1; cos_flag[2] = 1; cos_prio[6 +: 3] = 5;
    probe(8'hB1, "R6 break beats cos, rx, tx");

    // R7: strict threshold
    thresh = 8'hB0; tick(); tick();
    @(negedge clk);
    chk(irq_n === 1'b0, "R7 winner above thresh", irq_n, 0);
    thresh = 8'hB1; tick();
    @(negedge clk);
    chk(irq_n === 1'b1, "R7 winner equal thresh", irq_n, 1);

    // R11: evaluation disabled holds winner
    eval_en = 0; brk_flag = '0; cos_flag = '0; rx_fill = '0; tx_free = '0;
    tick();
    probe(8'hB1, "R11 latch held");
    eval_en = 1;
    probe(8'hFF, "R11 latch resumes");

    // Random phase, model compared every clock
    for (int n = 0; n < 4000; n++) begin
      tick();
      src_mask = 18'($urandom);
      for (int c = 0; c < 4; c++) begin
        rx_fill[c*4 +: 4] = 4'($urandom_range(0, 8));
        tx_free[c*4 +: 4] = 4'($urandom_range(0, 8));
      end
      rx_err = 4'($urandom); rx_lvl = 8'($urandom); tx_lvl = 8'($urandom);
      brk_flag = 4'($urandom); brk_prio = 12'($urandom);
      cos_flag = 4'($urandom); cos_prio = 12'($urandom);
      ct_flag = 2'($urandom); ct_prio = 6'($urandom);
      thresh = 8'($urandom); vec_base = 8'($urandom); vec_mode = 2'($urandom);
      eval_en = ($urandom_range(0, 7) != 0);
      iack = ($urandom_range(0, 6) == 0);
      upd = !iack && ($urandom_range(0, 9) == 0);
    end
    tick();
    iack = 0; upd = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule